// File: doc/BRIEF.md
# Dual-Bank SDRAM Command Rule Monitor

This block watches the command bus of a two-bank synchronous DRAM. On each clock it takes one decoded command with a bank select bit and the A10 qualifier. It keeps its own model of each bank: idle, open, waiting for an automatic precharge, or precharging. Any command that the bank state or the row/column timing does not allow is reported as a violation. The timing limits are parameters counted in clock cycles. The burst length and CAS latency parameters place the start of the automatic precharge that a READ with A10 high requests.

A command that is flagged never changes the model. The monitor therefore keeps following the device as a legal controller would have left it, and a single bad command does not cause a chain of false reports. Violations are reported one cycle after the command, as a pulse together with a one-hot code.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: After a synchronous reset, both banks read idle (state code 0) and `viol` is low with `viol_code` zero.
- R2: Command codes are NOP=0, ACT=1, READ=2, WRITE=3, PRE=4. An ACT to an idle bank opens it (state code 1). An ACT to an open bank, or a READ or WRITE to a bank that is not open, is flagged with code bit 4.
- R3: An ACT to one bank issued fewer than T_RRD cycles after an accepted ACT to the other bank is flagged with code bit 0. At exactly T_RRD cycles it is accepted.
- R4: A READ or WRITE issued fewer than T_RCD cycles after its bank's ACT is flagged with code bit 1. At exactly T_RCD cycles it is accepted.
- R5: PRE with A10 low moves the named open bank to precharging (state code 2). PRE to an idle bank has no effect and is not flagged.
- R6: A precharging bank returns to idle T_RP cycles after the precharge started, so an ACT at exactly T_RP cycles is accepted. An ACT before that point is flagged with code bit 2.
- R7: A precharge, explicit or all-bank, of a bank that has been open for fewer than T_RAS cycles is flagged with code bit 3.
- R8: PRE with A10 high closes every open bank in the same cycle.
- R9: A READ with A10 high moves its bank to state code 3. The internal precharge starts BL+CL-2 cycles after that READ, and the bank is idle T_RP cycles after that start. If the start would come before T_RAS cycles after the ACT, the READ is flagged with code bit 3.
- R10: Any non-NOP command that addresses a bank between an auto-precharge READ and the end of its internal precharge is flagged with code bit 5. This includes an all-bank PRE.
- R11: `viol` pulses one cycle after an offending command, with exactly one bit of `viol_code` set. A flagged command changes no bank state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Decoded command: NOP=0, ACT=1, READ=2, WRITE=3, PRE=4 |
| ba | input | 1 | Bank select |
| a10 | input | 1 | All-bank qualifier on PRE, auto-precharge request on READ |
| bank_state | output | 4 | Bank 1 state in [3:2], bank 0 in [1:0]: 0 idle, 1 open, 2 precharging, 3 auto-precharge pending |
| viol | output | 1 | One-cycle pulse for a flagged command |
| viol_code | output | 6 | One-hot cause: bit0 tRRD, bit1 tRCD, bit2 tRP, bit3 tRAS, bit4 bank state, bit5 auto-precharge busy |

## Verification
The bench builds the monitor with T_RRD=2, T_RCD=3, T_RP=3, T_RAS=9, CL=3 and BL=4, which gives an auto-precharge delay of 5 cycles. Because T_RAS is larger than T_RCD plus that delay, a READ with auto-precharge issued right at T_RCD breaks tRAS, and one issued a cycle later does not, so both sides of the R9 limit are reachable. The short T_RRD and T_RP let every boundary be tried one cycle early and exactly on time within a short script. The script also covers an all-bank precharge that is refused because one bank is too young and, later, accepted for both banks.

// File: rtl/sdram_mon_pkg.sv
`timescale 1ns/1ps
package sdram_mon_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE     = 2'd0,
    BK_OPEN     = 2'd1,
    BK_CLOSING  = 2'd2,
    BK_AUTOWAIT = 2'd3
  } bank_st_e;

  localparam int V_W    = 6;
  localparam int V_RRD  = 0;
  localparam int V_RCD  = 1;
  localparam int V_RP   = 2;
  localparam int V_RAS  = 3;
  localparam int V_ST   = 4;
  localparam int V_BUSY = 5;

endpackage

// File: rtl/sdram_bank_tracker.sv
`timescale 1ns/1ps
module sdram_bank_tracker
  import sdram_mon_pkg::*;
#(
  parameter int CNT_W  = 5,
  parameter int T_RP   = 3,
  parameter int AP_DLY = 5,
  parameter int AP_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             open_i,
  input  logic             close_i,
  input  logic             auto_i,
  output logic [1:0]       state_o,
  output logic [CNT_W-1:0] elapsed_o,
  output logic             busy_o
);

  localparam logic [CNT_W-1:0] RP_LAST = CNT_W'(T_RP - 1);
  localparam logic [AP_W-1:0]  AP_LOAD = AP_W'(AP_DLY - 1);
  localparam logic [CNT_W-1:0] EL_MAX  = '1;

  bank_st_e         st;
  logic [CNT_W-1:0] el;
  logic [AP_W-1:0]  apc;
  logic             apf;

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= BK_IDLE;
      el  <= '0;
      apc <= '0;
      apf <= 1'b0;
    end else begin
      if (el != EL_MAX) el <= el + 1'b1;
      case (st)
        BK_IDLE: begin
          if (open_i) begin
            st <= BK_OPEN;
            el <= CNT_W'(1);
          end
        end
        BK_OPEN: begin
          if (close_i) begin
            st  <= BK_CLOSING;
            el  <= CNT_W'(1);
            apf <= 1'b0;
          end else if (auto_i) begin
            st  <= BK_AUTOWAIT;
            apc <= AP_LOAD;
          end
        end
        BK_AUTOWAIT: begin
          if (apc == '0) begin
            st  <= BK_CLOSING;
            el  <= CNT_W'(1);
            apf <= 1'b1;
          end else begin
            apc <= apc - 1'b1;
          end
        end
        BK_CLOSING: begin
          if (el >= RP_LAST) begin
            st  <= BK_IDLE;
            apf <= 1'b0;
          end
        end
        default: st <= BK_IDLE;
      endcase
    end
  end

  assign state_o   = st;
  assign elapsed_o = el;
  assign busy_o    = (st == BK_AUTOWAIT) || ((st == BK_CLOSING) && apf);

  // R2: the rule logic only opens a bank that is idle
  a_r2_open_from_idle: assert property (@(posedge clk) disable iff (rst)
    open_i |-> st == BK_IDLE);

  // R5: the rule logic only closes a bank that is open
  a_r5_close_from_open: assert property (@(posedge clk) disable iff (rst)
    close_i |-> st == BK_OPEN);

  // R9: the bank waits while the auto-precharge countdown runs
  a_r9_autowait_hold: assert property (@(posedge clk) disable iff (rst)
    (st == BK_AUTOWAIT && apc != '0) |=> st == BK_AUTOWAIT);

  // R9: the internal precharge starts when the countdown ends
  a_r9_autowait_release: assert property (@(posedge clk) disable iff (rst)
    (st == BK_AUTOWAIT && apc == '0) |=> st == BK_CLOSING);

  // R6: a precharging bank never reopens without passing through idle
  a_r6_no_direct_reopen: assert property (@(posedge clk) disable iff (rst)
    st == BK_CLOSING |=> st != BK_OPEN);

endmodule

// File: rtl/sdram_act_spacing.sv
`timescale 1ns/1ps
module sdram_act_spacing #(
  parameter int CNT_W = 5,
  parameter int T_RRD = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic act_go_i,
  input  logic act_bank_i,
  input  logic q_bank_i,
  output logic block_o
);

  localparam logic [CNT_W-1:0] RRD_L  = CNT_W'(T_RRD);
  localparam logic [CNT_W-1:0] GAP_MX = '1;

  logic             seen;
  logic             last_bank;
  logic [CNT_W-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen      <= 1'b0;
      last_bank <= 1'b0;
      gap       <= '0;
    end else if (act_go_i) begin
      seen      <= 1'b1;
      last_bank <= act_bank_i;
      gap       <= CNT_W'(1);
    end else if (gap != GAP_MX) begin
      gap <= gap + 1'b1;
    end
  end

  assign block_o = seen && (q_bank_i != last_bank) && (gap < RRD_L);

  // R3: an accepted ACT never lands inside the other bank's spacing window
  a_r3_act_spacing: assert property (@(posedge clk) disable iff (rst)
    (act_go_i && seen && act_bank_i != last_bank) |-> gap >= RRD_L);

endmodule

// File: rtl/sdram_cmd_rules.sv
`timescale 1ns/1ps
module sdram_cmd_rules
  import sdram_mon_pkg::*;
#(
  parameter int NB     = 2,
  parameter int CNT_W  = 5,
  parameter int T_RCD  = 3,
  parameter int T_RAS  = 7,
  parameter int AP_DLY = 5
) (
  input  logic [2:0]                 cmd_i,
  input  logic                       ba_i,
  input  logic                       a10_i,
  input  logic [NB-1:0][1:0]         st_i,
  input  logic [NB-1:0][CNT_W-1:0]   el_i,
  input  logic [NB-1:0]              busy_i,
  input  logic                       rrd_block_i,
  output logic [V_W-1:0]             code_o,
  output logic [NB-1:0]              open_go_o,
  output logic [NB-1:0]              close_go_o,
  output logic [NB-1:0]              auto_go_o
);

  localparam int               SPAN_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] RCD_L  = CNT_W'(T_RCD);
  localparam logic [CNT_W-1:0] RAS_L  = CNT_W'(T_RAS);
  localparam logic [SPAN_W-1:0] RAS_W = SPAN_W'(T_RAS);
  localparam logic [SPAN_W-1:0] AP_L  = SPAN_W'(AP_DLY);

  logic [1:0]        sel_st;
  logic [CNT_W-1:0]  sel_el;
  logic              sel_busy;
  logic [SPAN_W-1:0] ap_span;
  logic [NB-1:0]     is_open;
  logic [NB-1:0]     too_young;

  assign sel_st   = st_i[ba_i];
  assign sel_el   = el_i[ba_i];
  assign sel_busy = busy_i[ba_i];
  assign ap_span  = {1'b0, sel_el} + AP_L;

  for (genvar b = 0; b < NB; b++) begin : g_age
    assign is_open[b]   = (st_i[b] == BK_OPEN);
    assign too_young[b] = is_open[b] && (el_i[b] < RAS_L);
  end

  always_comb begin
    code_o     = '0;
    open_go_o  = '0;
    close_go_o = '0;
    auto_go_o  = '0;
    case (cmd_e'(cmd_i))
      CMD_ACT: begin
        if (sel_busy)                 code_o[V_BUSY] = 1'b1;
        else if (sel_st == BK_OPEN)   code_o[V_ST]   = 1'b1;
        else if (sel_st == BK_CLOSING) code_o[V_RP]  = 1'b1;
        else if (rrd_block_i)         code_o[V_RRD]  = 1'b1;
        else                          open_go_o[ba_i] = 1'b1;
      end
      CMD_RD, CMD_WR: begin
        if (sel_busy)                 code_o[V_BUSY] = 1'b1;
        else if (sel_st != BK_OPEN)   code_o[V_ST]   = 1'b1;
        else if (sel_el < RCD_L)      code_o[V_RCD]  = 1'b1;
        else if (cmd_e'(cmd_i) == CMD_RD && a10_i) begin
          if (ap_span < RAS_W)        code_o[V_RAS]  = 1'b1;
          else                        auto_go_o[ba_i] = 1'b1;
        end
      end
      CMD_PRE: begin
        if (a10_i) begin
          if (|busy_i)                code_o[V_BUSY] = 1'b1;
          else if (|too_young)        code_o[V_RAS]  = 1'b1;
          else                        close_go_o     = is_open;
        end else begin
          if (sel_busy)               code_o[V_BUSY] = 1'b1;
          else if (too_young[ba_i])   code_o[V_RAS]  = 1'b1;
          else if (is_open[ba_i])     close_go_o[ba_i] = 1'b1;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sdram_cmd_monitor.sv
`timescale 1ns/1ps
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int T_RRD = 2,
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RAS = 7,
  parameter int CL    = 3,
  parameter int BL    = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [2:0]     cmd,
  input  logic           ba,
  input  logic           a10,
  output logic [3:0]     bank_state,
  output logic           viol,
  output logic [V_W-1:0] viol_code
);

  localparam int NB     = 2;
  localparam int AP_DLY = BL + CL - 2;
  localparam int AP_W   = (AP_DLY < 2) ? 1 : $clog2(AP_DLY + 1);
  localparam int CNT_W  = $clog2(T_RRD + T_RCD + T_RP + T_RAS + AP_DLY + 2);
  localparam logic [CNT_W-1:0] RCD_L = CNT_W'(T_RCD);

  logic [NB-1:0][1:0]       st_all;
  logic [NB-1:0][CNT_W-1:0] el_all;
  logic [NB-1:0]            busy_all;
  logic [NB-1:0]            open_go, close_go, auto_go;
  logic                     rrd_block;
  logic [V_W-1:0]           code_n;

  for (genvar g = 0; g < NB; g++) begin : g_bank
    sdram_bank_tracker #(
      .CNT_W (CNT_W),
      .T_RP  (T_RP),
      .AP_DLY(AP_DLY),
      .AP_W  (AP_W)
    ) u_bank (
      .clk      (clk),
      .rst      (rst),
      .open_i   (open_go[g]),
      .close_i  (close_go[g]),
      .auto_i   (auto_go[g]),
      .state_o  (st_all[g]),
      .elapsed_o(el_all[g]),
      .busy_o   (busy_all[g])
    );
  end

  sdram_act_spacing #(
    .CNT_W(CNT_W),
    .T_RRD(T_RRD)
  ) u_rrd (
    .clk       (clk),
    .rst       (rst),
    .act_go_i  (|open_go),
    .act_bank_i(open_go[1]),
    .q_bank_i  (ba),
    .block_o   (rrd_block)
  );

  sdram_cmd_rules #(
    .NB    (NB),
    .CNT_W (CNT_W),
    .T_RCD (T_RCD),
    .T_RAS (T_RAS),
    .AP_DLY(AP_DLY)
  ) u_rules (
    .cmd_i      (cmd),
    .ba_i       (ba),
    .a10_i      (a10),
    .st_i       (st_all),
    .el_i       (el_all),
    .busy_i     (busy_all),
    .rrd_block_i(rrd_block),
    .code_o     (code_n),
    .open_go_o  (open_go),
    .close_go_o (close_go),
    .auto_go_o  (auto_go)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      viol      <= 1'b0;
      viol_code <= '0;
    end else begin
      viol      <= |code_n;
      viol_code <= code_n;
    end
  end

  assign bank_state = st_all;

  // R11: a reported violation carries exactly one cause
  a_r11_one_cause: assert property (@(posedge clk) disable iff (rst)
    viol |-> $countones(viol_code) == 1);

  // R11: no cause is shown without the pulse
  a_r11_quiet_code: assert property (@(posedge clk) disable iff (rst)
    !viol |-> viol_code == '0);

  // R11: a flagged command moves no bank
  a_r11_flag_no_move: assert property (@(posedge clk) disable iff (rst)
    (code_n != '0) |-> (open_go == '0 && close_go == '0 && auto_go == '0));

  // R4: an unflagged READ or WRITE saw at least T_RCD cycles of open time
  a_r4_access_gap: assert property (@(posedge clk) disable iff (rst)
    ((cmd == CMD_RD || cmd == CMD_WR) && code_n == '0) |-> el_all[ba] >= RCD_L);

endmodule

// File: tb/sim_sdram_cmd_monitor.sv
`timescale 1ns/1ps
module sim_sdram_cmd_monitor;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] cmd = 3'd0;
  logic       ba  = 1'b0;
  logic       a10 = 1'b0;
  logic [3:0] bank_state;
  logic       viol;
  logic [5:0] viol_code;

  int  compared   = 0;
  int  mismatched = 0;
  bit  done       = 1'b0;

  logic [5:0] exp_code_q[$];
  logic [3:0] exp_st_q[$];
  string      tag_q[$];

  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3, PRE = 3'd4;
  localparam logic [5:0] OK = 6'd0, E_RRD = 6'b000001, E_RCD = 6'b000010,
                         E_RP = 6'b000100, E_RAS = 6'b001000,
                         E_ST = 6'b010000, E_BUSY = 6'b100000;

  always #2.5 clk = ~clk;

  sdram_cmd_monitor #(
    .T_RRD(2), .T_RCD(3), .T_RP(3), .T_RAS(9), .CL(3), .BL(4)
  ) u0 (
    .clk(clk), .rst(rst), .cmd(cmd), .ba(ba), .a10(a10),
    .bank_state(bank_state), .viol(viol), .viol_code(viol_code)
  );

  task automatic step(input logic [2:0] c, input logic b, input logic a,
                      input logic [5:0] ec, input logic [3:0] es, input string tag);
    @(negedge clk);
    cmd = c; ba = b; a10 = a;
    exp_code_q.push_back(ec);
    exp_st_q.push_back(es);
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (!rst && exp_code_q.size() != 0) begin
      logic [5:0] ec;
      logic [3:0] es;
      string      t;
      ec = exp_code_q.pop_front();
      es = exp_st_q.pop_front();
      t  = tag_q.pop_front();
      compared++;
      if (viol_code !== ec || viol !== (ec != 6'd0) || bank_state !== es) begin
        mismatched++;
        $display("FAIL %s: actual viol=%b code=%b state=%b, expected viol=%b code=%b state=%b",
                 t, viol, viol_code, bank_state, (ec != 6'd0), ec, es);
      end
    end
  end

  initial begin
    #20000;
    if (!done) begin
      mismatched++;
      $display("FAIL R11 watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    step(NOP, 0, 0, OK,    4'b0000, "R1 reset state");
    step(RD,  0, 0, E_ST,  4'b0000, "R2 read to idle bank");
    step(ACT, 0, 0, OK,    4'b0001, "R2 open bank0");
    step(ACT, 1, 0, E_RRD, 4'b0001, "R3 act spacing one cycle");
    step(ACT, 1, 0, OK,    4'b0101, "R3 act spacing exact");
    step(RD,  1, 0, E_RCD, 4'b0101, "R4 read one cycle after act");
    step(RD,  0, 0, OK,    4'b0101, "R4 read past tRCD");
    step(ACT, 0, 0, E_ST,  4'b0101, "R2 act to open bank");
    step(PRE, 0, 0, E_RAS, 4'b0101, "R7 early explicit precharge");
    step(WR,  1, 0, OK,    4'b0101, "R4 write past tRCD");
    step(NOP, 0, 0, OK,    4'b0101, "R11 idle cycle");
    step(PRE, 0, 0, OK,    4'b0110, "R5 precharge bank0");
    step(ACT, 0, 0, E_RP,  4'b0110, "R6 act during precharge");
    step(NOP, 0, 0, OK,    4'b0100, "R6 bank0 back to idle");
    step(ACT, 0, 0, OK,    4'b0101, "R6 act exactly tRP");
    step(RD,  1, 1, OK,    4'b1101, "R9 read with auto-precharge");
    step(RD,  1, 0, E_BUSY,4'b1101, "R10 read during auto wait");
    step(PRE, 0, 1, E_BUSY,4'b1101, "R10 R11 all-bank refused, bank0 kept");
    step(RD,  0, 0, OK,    4'b1101, "R9 other bank still usable");
    step(NOP, 0, 0, OK,    4'b1101, "R9 wait before start");
    step(NOP, 0, 0, OK,    4'b1001, "R9 internal precharge start");
    step(ACT, 1, 0, E_BUSY,4'b1001, "R10 act during internal precharge");
    step(NOP, 0, 0, OK,    4'b0001, "R9 bank1 idle after tRP");
    step(ACT, 1, 0, OK,    4'b0101, "R9 act tRP after internal start");
    step(RD,  1, 1, E_RCD, 4'b0101, "R4 auto read too early");
    step(NOP, 0, 0, OK,    4'b0101, "R11 idle cycle");
    step(RD,  1, 1, E_RAS, 4'b0101, "R9 auto start breaks tRAS");
    step(RD,  1, 1, OK,    4'b1101, "R9 auto start meets tRAS");
    for (int i = 0; i < 4; i++) step(NOP, 0, 0, OK, 4'b1101, "R9 auto wait");
    step(NOP, 0, 0, OK,    4'b1001, "R9 second internal start");
    step(NOP, 0, 0, OK,    4'b1001, "R9 precharging");
    step(NOP, 0, 0, OK,    4'b0001, "R9 idle again");
    step(ACT, 1, 0, OK,    4'b0101, "R2 reopen bank1");
    step(ACT, 0, 0, E_ST,  4'b0101, "R2 act to open bank0");
    step(PRE, 0, 1, E_RAS, 4'b0101, "R7 R11 all-bank with young bank");
    for (int i = 0; i < 6; i++) step(NOP, 0, 0, OK, 4'b0101, "R11 both open");
    step(PRE, 0, 1, OK,    4'b1010, "R8 all-bank precharge");
    step(NOP, 0, 0, OK,    4'b1010, "R8 both precharging");
    step(NOP, 0, 0, OK,    4'b0000, "R8 both idle");
    step(PRE, 0, 0, OK,    4'b0000, "R5 precharge idle bank");
    step(WR,  1, 0, E_ST,  4'b0000, "R2 write to idle bank");
    step(NOP, 0, 0, OK,    4'b0000, "R1 final idle");
    @(negedge clk);
    while (exp_code_q.size() != 0) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule